// File: doc/BRIEF.md
# Vertical Panel Drive Timing Generator

This block produces the vertical scan signals for an active-matrix display panel: a start pulse, a line clock, a gate-enable pulse and a precharge line. The precharge line also carries a once-per-frame blanking pulse. A frame strobe starts each frame and a line strobe starts each scan line. The line clock changes level once per accepted line, so the panel's shift register advances on alternate rising and falling edges.

At each frame strobe the block samples the active-area mode and the scan direction. It then issues the blanking pulse and waits a guard interval. After that it raises the start pulse on the first line whose clock edge has the polarity the chosen direction needs. From that edge on it issues exactly as many line-clock edges as the mode calls for. All pulse delays and widths are parameters counted in system clocks. An optional output register stage delays every output by the same one cycle.

Top module: `vpanel_vtiming`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted strobe, the outputs vst, vck, enb, pcg and blk are all low.
- R2: The mode is sampled at the frame strobe. Encoding 0 gives LINES_M0 lines, 1 gives LINES_M1, 2 gives LINES_M2 and 3 gives LINES_M3. The frame then has exactly that many vck edges, counted from the edge that samples vst. A mode change after the strobe has no effect on the current frame.
- R3: For each accepted line, the precharge pulse rises exactly PCG_LEAD cycles before that line's vck edge and stays high for PCG_WID cycles.
- R4: enb rises exactly ENB_DLY cycles after each vck edge and stays high for ENB_WID cycles. It is low in every cycle in which vck changes.
- R5: pcg is the OR of the precharge pulse and blk, so pcg is high whenever blk is high.
- R6: Each frame strobe produces exactly one blk pulse of BLK_WID cycles, starting one cycle after the strobe.
- R7: vst rises no sooner than BLK_TO_VST cycles after blk falls. vst is low while blk is high.
- R8: The scan direction is sampled at the frame strobe. With scan_down = 1, vst spans exactly one vck edge and that edge is rising. With scan_down = 0, that single edge is falling. If the next edge has the wrong polarity, a line is run without vst first.
- R9: vst rises PCG_LEAD cycles before the vck edge that samples it and falls VST_HOLD cycles after that edge.
- R10: A line strobe is ignored while its line sequence is still running. It is also ignored before the first frame, during blanking and the guard interval, and once the frame's lines are complete. An ignored strobe causes no vck edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Active-area mode, sampled at frame strobe |
| scan_down | input | 1 | 1 = normal downward scan, 0 = reversed scan |
| line_stb | input | 1 | One-cycle line start request |
| frame_stb | input | 1 | One-cycle frame start request; has priority over line_stb |
| vst | output | 1 | Vertical start pulse |
| vck | output | 1 | Vertical line clock, one level change per line |
| enb | output | 1 | Gate enable pulse |
| pcg | output | 1 | Precharge OR blanking pulse |
| blk | output | 1 | Blanking pulse, once per frame |

## Verification
The bench builds the block with 7, 6, 5 and 4 lines for the four modes, a 3-cycle precharge lead, 4-cycle precharge, 1-cycle enable delay, 5-cycle enable, 6-cycle blanking, 4-cycle guard and 2-cycle start hold. With these values a whole frame lasts about a hundred cycles. The bench can therefore sweep every mode in both scan directions in sequence. Because the line-clock level carries over from frame to frame, this sweep reaches both start-pulse phases, with and without the extra unsampled line. Every edge, pulse width and per-frame line count is measured against the parameter arithmetic. Surplus and mid-line strobes are also applied, to show that they are ignored.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   typedef enum logic [2:0] {
      FS_IDLE  = 3'd0,
      FS_BLANK = 3'd1,
      FS_GAP   = 3'd2,
      FS_ARMED = 3'd3,
      FS_SCAN  = 3'd4
   } fseq_state_t;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vtg_line_seq.sv
module vtg_line_seq
   import vtg_pkg::*;
#(
   parameter int unsigned PCG_LEAD = 125,
   parameter int unsigned PCG_WID  = 150,
   parameter int unsigned ENB_DLY  = 63,
   parameter int unsigned ENB_WID  = 313,
   parameter int unsigned VST_HOLD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic vck_lvl,
   output logic pcg_pre,
   output logic enb,
   output logic vst_drop
);

   localparam int unsigned SEQ_LEN = umax(umax(PCG_WID, PCG_LEAD + ENB_DLY + ENB_WID),
                                          PCG_LEAD + VST_HOLD);
   localparam int unsigned T_W     = $clog2(SEQ_LEN + 1);

   localparam logic [T_W-1:0] T_END    = T_W'(SEQ_LEN);
   localparam logic [T_W-1:0] T_EDGE   = T_W'(PCG_LEAD);
   localparam logic [T_W-1:0] T_PCG_HI = T_W'(PCG_WID);
   localparam logic [T_W-1:0] T_ENB_LO = T_W'(PCG_LEAD + ENB_DLY + 1);
   localparam logic [T_W-1:0] T_ENB_HI = T_W'(PCG_LEAD + ENB_DLY + ENB_WID);
   localparam logic [T_W-1:0] T_DROP   = T_W'(PCG_LEAD + VST_HOLD);

   logic [T_W-1:0] t_q;
   logic           vck_q;

   // line phase counter: 0 = idle, 1..SEQ_LEN = running
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q <= '0;
      end else if (start && (t_q == '0)) begin
         t_q <= T_W'(1);
      end else if (t_q == T_END) begin
         t_q <= '0;
      end else if (t_q != '0) begin
         t_q <= t_q + T_W'(1);
      end
   end

   // line clock changes level once per line, PCG_LEAD cycles after start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vck_q <= 1'b0;
      end else if (t_q == T_EDGE) begin
         vck_q <= ~vck_q;
      end
   end

   assign busy     = (t_q != '0);
   assign vck_lvl  = vck_q;
   assign pcg_pre  = (t_q != '0) && (t_q <= T_PCG_HI);
   assign enb      = (t_q >= T_ENB_LO) && (t_q <= T_ENB_HI);
   assign vst_drop = (t_q == T_DROP);

endmodule

// File: rtl/vtg_frame_seq.sv
module vtg_frame_seq
   import vtg_pkg::*;
#(
   parameter int unsigned LINES_M0   = 604,
   parameter int unsigned LINES_M1   = 572,
   parameter int unsigned LINES_M2   = 484,
   parameter int unsigned LINES_M3   = 404,
   parameter int unsigned LINE_CNT_W = 10,
   parameter int unsigned DLY_W      = 16,
   parameter int unsigned BLK_WID    = 2625,
   parameter int unsigned BLK_TO_VST = 4125
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_stb,
   input  logic       line_stb,
   input  logic [1:0] mode_sel,
   input  logic       scan_down,
   input  logic       line_busy,
   input  logic       vck_lvl,
   input  logic       vst_drop,
   output logic       line_start,
   output logic       blk,
   output logic       vst
);

   localparam int unsigned        N_MODES = 4;
   localparam logic [DLY_W-1:0]   C_BLK   = DLY_W'(BLK_WID);
   localparam logic [DLY_W-1:0]   C_GAP   = DLY_W'(BLK_TO_VST);

   logic [LINE_CNT_W-1:0] lines_lut [N_MODES];

   for (genvar g = 0; g < N_MODES; g++) begin : g_lut
      localparam int unsigned NL = (g == 0) ? LINES_M0 :
                                   (g == 1) ? LINES_M1 :
                                   (g == 2) ? LINES_M2 : LINES_M3;
      assign lines_lut[g] = LINE_CNT_W'(NL);
   end

   fseq_state_t           state_q;
   logic [DLY_W-1:0]      cnt_q;
   logic [LINE_CNT_W-1:0] lines_q;
   logic [LINE_CNT_W-1:0] started_q;
   logic                  down_q;
   logic                  vst_q;

   logic accept;
   logic phase_ok;
   logic scan_more;

   assign accept    = line_stb && !frame_stb && !line_busy;
   // down scan needs a rising edge next (clock low now); up scan a falling one
   assign phase_ok  = (vck_lvl != down_q);
   assign scan_more = (started_q < lines_q);

   always_comb begin
      line_start = 1'b0;
      unique case (state_q)
         FS_ARMED: line_start = accept;
         FS_SCAN:  line_start = accept && scan_more;
         default:  line_start = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= FS_IDLE;
         cnt_q     <= '0;
         lines_q   <= '0;
         started_q <= '0;
         down_q    <= 1'b1;
         vst_q     <= 1'b0;
      end else if (frame_stb) begin
         state_q   <= FS_BLANK;
         cnt_q     <= DLY_W'(1);
         lines_q   <= lines_lut[mode_sel];
         started_q <= '0;
         down_q    <= scan_down;
         vst_q     <= 1'b0;
      end else begin
         unique case (state_q)
            FS_BLANK: begin
               if (cnt_q == C_BLK) begin
                  state_q <= FS_GAP;
                  cnt_q   <= DLY_W'(1);
               end else begin
                  cnt_q <= cnt_q + DLY_W'(1);
               end
            end
            FS_GAP: begin
               if (cnt_q == C_GAP) begin
                  state_q <= FS_ARMED;
               end else begin
                  cnt_q <= cnt_q + DLY_W'(1);
               end
            end
            FS_ARMED: begin
               if (accept && phase_ok) begin
                  state_q   <= FS_SCAN;
                  started_q <= LINE_CNT_W'(1);
                  vst_q     <= 1'b1;
               end
            end
            FS_SCAN: begin
               if (line_start) begin
                  started_q <= started_q + LINE_CNT_W'(1);
               end
               if (vst_drop) begin
                  vst_q <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   assign blk = (state_q == FS_BLANK);
   assign vst = vst_q;

endmodule

// File: rtl/vpanel_vtiming.sv
module vpanel_vtiming #(
   parameter int unsigned LINES_M0   = 604,
   parameter int unsigned LINES_M1   = 572,
   parameter int unsigned LINES_M2   = 484,
   parameter int unsigned LINES_M3   = 404,
   parameter int unsigned LINE_CNT_W = 10,
   parameter int unsigned DLY_W      = 16,
   parameter int unsigned PCG_LEAD   = 125,
   parameter int unsigned PCG_WID    = 150,
   parameter int unsigned ENB_DLY    = 63,
   parameter int unsigned ENB_WID    = 313,
   parameter int unsigned BLK_WID    = 2625,
   parameter int unsigned BLK_TO_VST = 4125,
   parameter int unsigned VST_HOLD   = 8,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic       scan_down,
   input  logic       line_stb,
   input  logic       frame_stb,
   output logic       vst,
   output logic       vck,
   output logic       enb,
   output logic       pcg,
   output logic       blk
);

   localparam int unsigned LINE_MAX = 2 ** LINE_CNT_W;
   localparam int unsigned DLY_MAX  = 2 ** DLY_W;

   // elaboration-time parameter checks
   if (PCG_LEAD < 1) begin : g_bad_lead
      $error("PCG_LEAD must be at least 1");
   end
   if (ENB_DLY < 1 || ENB_WID < 1 || PCG_WID < 1) begin : g_bad_enb
      $error("ENB_DLY, ENB_WID and PCG_WID must be at least 1");
   end
   if (VST_HOLD < 1 || BLK_WID < 1 || BLK_TO_VST < 1) begin : g_bad_frame
      $error("VST_HOLD, BLK_WID and BLK_TO_VST must be at least 1");
   end
   if (BLK_WID >= DLY_MAX || BLK_TO_VST >= DLY_MAX) begin : g_bad_dlyw
      $error("DLY_W too narrow for blanking counts");
   end
   if (LINES_M0 >= LINE_MAX || LINES_M1 >= LINE_MAX ||
       LINES_M2 >= LINE_MAX || LINES_M3 >= LINE_MAX ||
       LINES_M0 < 1 || LINES_M1 < 1 || LINES_M2 < 1 || LINES_M3 < 1) begin : g_bad_lines
      $error("line counts must be nonzero and fit LINE_CNT_W");
   end

   logic line_start;
   logic line_busy;
   logic vck_i;
   logic pcg_pre_i;
   logic enb_i;
   logic vst_drop;
   logic blk_i;
   logic vst_i;

   vtg_frame_seq #(
      .LINES_M0   (LINES_M0),
      .LINES_M1   (LINES_M1),
      .LINES_M2   (LINES_M2),
      .LINES_M3   (LINES_M3),
      .LINE_CNT_W (LINE_CNT_W),
      .DLY_W      (DLY_W),
      .BLK_WID    (BLK_WID),
      .BLK_TO_VST (BLK_TO_VST)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .line_stb   (line_stb),
      .mode_sel   (mode_sel),
      .scan_down  (scan_down),
      .line_busy  (line_busy),
      .vck_lvl    (vck_i),
      .vst_drop   (vst_drop),
      .line_start (line_start),
      .blk        (blk_i),
      .vst        (vst_i)
   );

   vtg_line_seq #(
      .PCG_LEAD (PCG_LEAD),
      .PCG_WID  (PCG_WID),
      .ENB_DLY  (ENB_DLY),
      .ENB_WID  (ENB_WID),
      .VST_HOLD (VST_HOLD)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (line_start),
      .busy     (line_busy),
      .vck_lvl  (vck_i),
      .pcg_pre  (pcg_pre_i),
      .enb      (enb_i),
      .vst_drop (vst_drop)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vst <= 1'b0;
            vck <= 1'b0;
            enb <= 1'b0;
            pcg <= 1'b0;
            blk <= 1'b0;
         end else begin
            vst <= vst_i;
            vck <= vck_i;
            enb <= enb_i;
            pcg <= pcg_pre_i | blk_i;
            blk <= blk_i;
         end
      end
   end else begin : g_out_comb
      assign vst = vst_i;
      assign vck = vck_i;
      assign enb = enb_i;
      assign pcg = pcg_pre_i | blk_i;
      assign blk = blk_i;
   end

endmodule

// File: rtl/vpanel_vtiming_chk.sv
module vpanel_vtiming_chk #(
   parameter int unsigned ENB_WID = 313,
   parameter int unsigned BLK_WID = 2625
) (
   input logic clk,
   input logic rst_n,
   input logic vst,
   input logic vck,
   input logic enb,
   input logic pcg,
   input logic blk
);

   int unsigned enb_run_q;
   int unsigned blk_run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enb_run_q <= 0;
         blk_run_q <= 0;
      end else begin
         enb_run_q <= enb ? enb_run_q + 1 : 0;
         blk_run_q <= blk ? blk_run_q + 1 : 0;
      end
   end

   p_blk_in_pcg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      blk |-> pcg);

   p_enb_quiet_at_vck_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vck != $past(vck)) |-> !enb);

   p_enb_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      enb_run_q <= ENB_WID);

   p_blk_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      blk_run_q <= BLK_WID);

   p_vst_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vst) |-> $stable(vck));

   p_vst_off_in_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      blk |-> !vst);

endmodule

bind vpanel_vtiming vpanel_vtiming_chk #(
   .ENB_WID (ENB_WID),
   .BLK_WID (BLK_WID)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .vst   (vst),
   .vck   (vck),
   .enb   (enb),
   .pcg   (pcg),
   .blk   (blk)
);

// File: tb/tb_vpanel_vtiming.sv
module tb_vpanel_vtiming;

   localparam int LA = 7, LB = 6, LC = 5, LD = 4;
   localparam int PL = 3, PW = 4, ED = 1, EW = 5;
   localparam int BW = 6, BG = 4, VH = 2;
   localparam int LP = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic       scan_down = 1'b1;
   logic       line_stb = 1'b0;
   logic       frame_stb = 1'b0;
   logic       vst, vck, enb, pcg, blk;

   vpanel_vtiming #(
      .LINES_M0 (LA), .LINES_M1 (LB), .LINES_M2 (LC), .LINES_M3 (LD),
      .LINE_CNT_W (4), .DLY_W (8),
      .PCG_LEAD (PL), .PCG_WID (PW), .ENB_DLY (ED), .ENB_WID (EW),
      .BLK_WID (BW), .BLK_TO_VST (BG), .VST_HOLD (VH)
   ) dut (
      .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel), .scan_down (scan_down),
      .line_stb (line_stb), .frame_stb (frame_stb),
      .vst (vst), .vck (vck), .enb (enb), .pcg (pcg), .blk (blk)
   );

   always #4 clk = ~clk;

   int  vectors = 0;
   int  fails = 0;
   bit  done = 0;
   bit  mon_on = 0;
   int  cyc = 0;

   logic p_vst = 0, p_vck = 0, p_enb = 0, p_pcg = 0, p_blk = 0;
   int  last_vck_edge = 0, last_pcg_rise = 0, last_enb_rise = 0;
   int  blk_rise = 0, blk_fall = 0, vst_rise = 0;
   int  vst_edges = 0, edges_after_vst = 0, blk_count = 0;
   bit  vst_seen = 0;
   bit  exp_down = 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int lines_of(input int m);
      case (m)
         0: return LA;
         1: return LB;
         2: return LC;
         default: return LD;
      endcase
   endfunction

   // monitor: outputs sampled at the falling edge
   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (vck != p_vck) begin
            chk(cyc - last_pcg_rise == PL, "R3 precharge lead", cyc - last_pcg_rise, PL);
            chk(!blk, "R10 no vck edge in blanking", int'(blk), 0);
            if (vst) begin
               chk(vck == exp_down, "R8 sampling edge polarity", int'(vck), int'(exp_down));
               chk(cyc - vst_rise == PL, "R9 vst setup", cyc - vst_rise, PL);
               vst_edges++;
               vst_seen = 1;
               edges_after_vst = 1;
            end else if (vst_seen) begin
               edges_after_vst++;
            end
            last_vck_edge = cyc;
         end
         if (enb && !p_enb) begin
            chk(cyc - last_vck_edge == ED, "R4 enable delay", cyc - last_vck_edge, ED);
            last_enb_rise = cyc;
         end
         if (!enb && p_enb)
            chk(cyc - last_enb_rise == EW, "R4 enable width", cyc - last_enb_rise, EW);
         if (pcg && !p_pcg && !blk)
            last_pcg_rise = cyc;
         if (!pcg && p_pcg && !p_blk)
            chk(cyc - last_pcg_rise == PW, "R3 precharge width", cyc - last_pcg_rise, PW);
         if (blk)
            chk(pcg, "R5 pcg covers blk", int'(pcg), 1);
         if (blk && !p_blk) begin
            blk_rise = cyc;
            blk_count++;
         end
         if (!blk && p_blk) begin
            chk(cyc - blk_rise == BW, "R6 blk width", cyc - blk_rise, BW);
            blk_fall = cyc;
         end
         if (vst && !p_vst) begin
            chk(cyc - blk_fall >= BG, "R7 blk fall to vst", cyc - blk_fall, BG);
            vst_rise = cyc;
            vst_edges = 0;
         end
         if (!vst && p_vst) begin
            chk(cyc - last_vck_edge == VH, "R9 vst hold", cyc - last_vck_edge, VH);
            chk(vst_edges == 1, "R8 one edge under vst", vst_edges, 1);
         end
         p_vst = vst; p_vck = vck; p_enb = enb; p_pcg = pcg; p_blk = blk;
      end
   end

   task automatic run_frame(input int m, input bit dn);
      @(negedge clk);
      mode_sel  = 2'(m);
      scan_down = dn;
      exp_down  = dn;
      vst_seen  = 0;
      edges_after_vst = 0;
      blk_count = 0;
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      // changes after the strobe must not matter (R2, R8)
      mode_sel  = 2'((m + 1) % 4);
      scan_down = ~dn;
      for (int k = 0; k < lines_of(m) + 6; k++) begin
         line_stb = 1'b1;
         @(negedge clk);
         line_stb = 1'b0;
         repeat (2) @(negedge clk);
         if (k >= 2) line_stb = 1'b1;   // mid-line strobe, must be ignored (R10)
         @(negedge clk);
         line_stb = 1'b0;
         repeat (LP - 4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(edges_after_vst == lines_of(m), "R2 lines per frame", edges_after_vst, lines_of(m));
      chk(blk_count == 1, "R6 one blk per frame", blk_count, 1);
      chk(vst_seen, "R8 vst sampled", int'(vst_seen), 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk({vst, vck, enb, pcg, blk} == 5'b0, "R1 outputs in reset",
          int'({vst, vck, enb, pcg, blk}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      repeat (3) @(negedge clk);
      chk({vst, vck, enb, pcg, blk} == 5'b0, "R1 outputs after reset",
          int'({vst, vck, enb, pcg, blk}), 0);
      // line strobes before any frame are ignored (R10)
      for (int i = 0; i < 3; i++) begin
         line_stb = 1'b1;
         @(negedge clk);
         line_stb = 1'b0;
         repeat (LP - 1) @(negedge clk);
      end
      chk(vck == 1'b0, "R10 idle strobes ignored", int'(vck), 0);
      chk(pcg == 1'b0, "R10 idle strobes no precharge", int'(pcg), 0);
      for (int d = 0; d < 2; d++)
         for (int m = 0; m < 4; m++)
            run_frame(m, d[0]);
      // repeat a pair so both vck phases meet both directions
      run_frame(3, 1'b1);
      run_frame(0, 1'b0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule